// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits behind the write port of a parallel NOR flash model and turns the host's multi-cycle command writes into actions. Each write carries a byte address and a data word. The block derives the word address from the byte address according to the bus width. It checks the two-step unlock handshake, decodes the command byte that follows, and then either issues a program request, starts a chip or sector erase toward an external erase controller, or switches the read path into an identifier or query mode.

An unlock-bypass state keeps the block past the handshake, so that repeated programs need only two writes each. A query mode entered from the identifier mode remembers where it came from, and the reset command returns it to the identifier mode. The storage array, the erase timing and the contents of the query table live outside the block. The array's current word at the write address arrives on `memData`, and the erase controller reports completion on `eraseDone`. The `mode` output tells the read mux which source to show.

Top module: `flash_cmd_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the block in read-array mode (`mode` = 0), with `bypassOn` low and all request outputs low. The `mode` encoding is 0 read array, 1 identifier, 2 query, 3 status.
- R2: An unlock consists of data low byte 0xAA at word address UNLOCK0 followed by 0x55 at word address UNLOCK1. The word address is the byte address shifted right by 0, 1 or 2 for 1-, 2- or 4-byte buses. Only word-address bits [10:0] are compared. A wrong address or wrong data returns the block to read-array mode.
- R3: The write after an unlock is the command cycle, and only the data low byte is decoded. Outside bypass it must hit UNLOCK0. 0x80 opens erase, 0x90 enters identifier mode, 0xA0 arms a program (`mode` = 3), 0x20 enters bypass, and any other value returns to read-array mode.
- R4: The write after an armed program pulses `progReq` in the following cycle. That pulse carries `progAddr` = word address and `progData` = `memData` AND write data. The block then returns to read-array mode, or to the command cycle in bypass.
- R5: Erase requires a second unlock pair. After it, 0x30 at any address pulses `sectorEraseReq` with `eraseSector` = word address >> SECTOR_LOG2, and 0x10 at UNLOCK0 pulses `chipEraseReq`. In both cases `mode` goes to 3. Anything else returns to read-array mode.
- R6: While an erase is in progress, every write is ignored, including 0xF0. A pulse on `eraseDone` ends the erase. The block then goes to read-array mode, or to the command cycle in bypass.
- R7: Writing 0x98 at word address 0x055 from read-array mode enters query mode (`mode` = 2). Any later write returns to read-array mode.
- R8: Writing 0x98 at word address 0x055 in identifier mode enters a query mode from which 0xF0 returns to identifier mode (`mode` = 1). Any other write returns to read-array mode.
- R9: Data 0xF0 returns to read-array mode and clears bypass in every other state. The exception is the armed program cycle, where 0xF0 is programmed as data.
- R10: In bypass (`bypassOn` high), the command-cycle address is not checked, each program needs only 0xA0 and the data write, and an ended erase returns to the command cycle.
- R11: In identifier mode under bypass, data 0x00 leaves bypass and returns to read-array mode.
- R12: Each request is a single-cycle pulse, and at most one of `progReq`, `chipEraseReq` and `sectorEraseReq` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Host write strobe, one cycle per write |
| byteAddr | input | ADDR_W | Host byte address |
| wrData | input | 8*BUS_BYTES | Host write data |
| memData | input | 8*BUS_BYTES | Array word currently stored at the write address |
| eraseDone | input | 1 | Erase controller finished the running erase |
| mode | output | 2 | Read source: 0 array, 1 identifier, 2 query, 3 status |
| bypassOn | output | 1 | Unlock bypass active |
| progReq | output | 1 | Program request pulse |
| progAddr | output | ADDR_W-log2(BUS_BYTES) | Word address to program |
| progData | output | 8*BUS_BYTES | Word to store (old AND new) |
| chipEraseReq | output | 1 | Chip erase request pulse |
| sectorEraseReq | output | 1 | Sector erase request pulse |
| eraseSector | output | ADDR_W-log2(BUS_BYTES)-SECTOR_LOG2 | Sector index of a sector erase |

## Verification
The bench builds the block with a 16-bit bus, a 14-bit byte address and SECTOR_LOG2 = 10. This gives 13 word-address bits and eight sectors. With that configuration, every one of the 256 command-byte values can be swept through the command cycle, and every sector can be erased in turn. Word addresses with bit 11 set fall within reach, so the 11-bit unlock aliasing can be tested, as can the ignored byte-lane bit. The array word is a computed function of the address, so each expected program result is a plain AND done in the bench.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,   // read array, waiting for first unlock
    ST_UNL1,   // first unlock seen
    ST_CMD,    // command cycle
    ST_PDATA,  // program armed, next write is data
    ST_AUTO,   // identifier mode
    ST_EUNL0,  // erase: second unlock, first half
    ST_EUNL1,  // erase: second unlock, second half
    ST_ECMD,   // erase: choose chip or sector
    ST_ERASE,  // erase running
    ST_CFIRD,  // query mode entered from read array
    ST_CFIAS   // query mode entered from identifier mode
  } seqStateT;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_QUERY  = 2'd2,
    MODE_STATUS = 2'd3
  } modeT;

  typedef struct packed {
    logic unl0;
    logic unl1;
    logic query;
  } addrHitT;

  typedef struct packed {
    logic prog;
    logic chip;
    logic sector;
  } stbT;

  function automatic int laneShift(input int busBytes);
    return (busBytes >= 4) ? 2 : (busBytes == 2) ? 1 : 0;
  endfunction

endpackage

// File: rtl/fseq_dp.sv
module fseq_dp import fseq_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int LANE_SH = 1,
  parameter int WA_W = 23,
  parameter int SECTOR_LOG2 = 15,
  parameter int SEC_W = 8,
  parameter logic [10:0] UNLOCK0 = 11'h555,
  parameter logic [10:0] UNLOCK1 = 11'h2AA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memData,
  input  stbT               stb,
  output addrHitT           hit,
  output logic              progReq,
  output logic [WA_W-1:0]   progAddr,
  output logic [DATA_W-1:0] progData,
  output logic              chipEraseReq,
  output logic              sectorEraseReq,
  output logic [SEC_W-1:0]  eraseSector
);

  localparam logic [10:0] QUERY_WORD = 11'h055;

  logic [WA_W-1:0] wordAddr;

  generate
    if (LANE_SH == 0) begin : g_byteBus
      assign wordAddr = byteAddr;
    end else begin : g_wideBus
      logic [LANE_SH-1:0] unusedLane;
      assign unusedLane = byteAddr[LANE_SH-1:0];
      assign wordAddr   = byteAddr[ADDR_W-1:LANE_SH];
    end
  endgenerate

  assign hit.unl0  = (wordAddr[10:0] == UNLOCK0);
  assign hit.unl1  = (wordAddr[10:0] == UNLOCK1);
  assign hit.query = (wordAddr[10:0] == QUERY_WORD);

  always_ff @(posedge clk) begin
    if (rst) begin
      progReq        <= 1'b0;
      chipEraseReq   <= 1'b0;
      sectorEraseReq <= 1'b0;
      progAddr       <= '0;
      progData       <= '0;
      eraseSector    <= '0;
    end else begin
      progReq        <= stb.prog;
      chipEraseReq   <= stb.chip;
      sectorEraseReq <= stb.sector;
      if (stb.prog) begin
        progAddr <= wordAddr;
        progData <= memData & wrData;
      end
      if (stb.sector) begin
        eraseSector <= wordAddr[WA_W-1:SECTOR_LOG2];
      end
    end
  end

  // R12
  req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({progReq, chipEraseReq, sectorEraseReq}));

  // R12
  prog_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    progReq |=> !progReq);

  // R4
  prog_clears_only_chk: assert property (@(posedge clk) disable iff (rst)
    progReq |-> ((progData & ~$past(memData)) == '0));

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl import fseq_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       eraseDone,
  input  logic [7:0] cmdByte,
  input  addrHitT    hit,
  output stbT        stb,
  output logic       bypassOn,
  output modeT       mode
);

  seqStateT state, nxtState;
  logic     bypass, nxtBypass;
  logic     doClear;

  always_comb begin
    nxtState  = state;
    nxtBypass = bypass;
    stb       = '0;
    doClear   = 1'b0;
    if (state == ST_ERASE && eraseDone) begin
      nxtState = bypass ? ST_CMD : ST_IDLE;
    end else if (wrEn) begin
      if (cmdByte == 8'hF0 && state != ST_PDATA && state != ST_ERASE) begin
        if (state == ST_CFIAS) nxtState = ST_AUTO;
        else                   doClear  = 1'b1;
      end else begin
        case (state)
          ST_IDLE: begin
            if (hit.query && cmdByte == 8'h98)     nxtState = ST_CFIRD;
            else if (hit.unl0 && cmdByte == 8'hAA) nxtState = ST_UNL1;
            else                                   doClear  = 1'b1;
          end
          ST_UNL1: begin
            if (hit.unl1 && cmdByte == 8'h55) nxtState = ST_CMD;
            else                              doClear  = 1'b1;
          end
          ST_CMD: begin
            if (!bypass && !hit.unl0) doClear = 1'b1;
            else begin
              case (cmdByte)
                8'h20:   nxtBypass = 1'b1;
                8'h80:   nxtState  = ST_EUNL0;
                8'h90:   nxtState  = ST_AUTO;
                8'hA0:   nxtState  = ST_PDATA;
                default: doClear   = 1'b1;
              endcase
            end
          end
          ST_PDATA: begin
            stb.prog = 1'b1;
            nxtState = bypass ? ST_CMD : ST_IDLE;
          end
          ST_AUTO: begin
            if (bypass && cmdByte == 8'h00)        doClear  = 1'b1;
            else if (hit.query && cmdByte == 8'h98) nxtState = ST_CFIAS;
            else                                    doClear  = 1'b1;
          end
          ST_EUNL0: begin
            if (hit.unl0 && cmdByte == 8'hAA) nxtState = ST_EUNL1;
            else                              doClear  = 1'b1;
          end
          ST_EUNL1: begin
            if (hit.unl1 && cmdByte == 8'h55) nxtState = ST_ECMD;
            else                              doClear  = 1'b1;
          end
          ST_ECMD: begin
            if (cmdByte == 8'h10 && hit.unl0) begin
              stb.chip = 1'b1;
              nxtState = ST_ERASE;
            end else if (cmdByte == 8'h30) begin
              stb.sector = 1'b1;
              nxtState   = ST_ERASE;
            end else begin
              doClear = 1'b1;
            end
          end
          ST_ERASE: ;
          default: doClear = 1'b1;
        endcase
      end
    end
    if (doClear) begin
      nxtState  = ST_IDLE;
      nxtBypass = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bypass <= 1'b0;
    end else begin
      state  <= nxtState;
      bypass <= nxtBypass;
    end
  end

  always_comb begin
    case (state)
      ST_AUTO:            mode = MODE_IDENT;
      ST_CFIRD, ST_CFIAS: mode = MODE_QUERY;
      ST_PDATA, ST_ERASE: mode = MODE_STATUS;
      default:            mode = MODE_ARRAY;
    endcase
  end

  assign bypassOn = bypass;

  // R6
  erase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERASE && !eraseDone) |=> (state == ST_ERASE));

  // R10
  bypass_state_chk: assert property (@(posedge clk) disable iff (rst)
    bypass |-> !(state inside {ST_IDLE, ST_UNL1, ST_CFIRD}));

  // R2
  unlock_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_UNL1 && wrEn && !hit.unl1) |=> (state == ST_IDLE && !bypass));

  // R8
  query_return_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CFIAS && wrEn && cmdByte == 8'hF0) |=> (state == ST_AUTO));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq import fseq_pkg::*; #(
  parameter int BUS_BYTES = 2,
  parameter int ADDR_W = 24,
  parameter int SECTOR_LOG2 = 15,
  parameter logic [10:0] UNLOCK0 = 11'h555,
  parameter logic [10:0] UNLOCK1 = 11'h2AA,
  localparam int DATA_W = 8 * BUS_BYTES,
  localparam int LANE_SH = laneShift(BUS_BYTES),
  localparam int WA_W = ADDR_W - LANE_SH,
  localparam int SEC_W = WA_W - SECTOR_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memData,
  input  logic              eraseDone,
  output logic [1:0]        mode,
  output logic              bypassOn,
  output logic              progReq,
  output logic [WA_W-1:0]   progAddr,
  output logic [DATA_W-1:0] progData,
  output logic              chipEraseReq,
  output logic              sectorEraseReq,
  output logic [SEC_W-1:0]  eraseSector
);

  addrHitT hit;
  stbT     stb;
  modeT    modeSig;

  fseq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .eraseDone(eraseDone),
    .cmdByte  (wrData[7:0]),
    .hit      (hit),
    .stb      (stb),
    .bypassOn (bypassOn),
    .mode     (modeSig)
  );

  fseq_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LANE_SH    (LANE_SH),
    .WA_W       (WA_W),
    .SECTOR_LOG2(SECTOR_LOG2),
    .SEC_W      (SEC_W),
    .UNLOCK0    (UNLOCK0),
    .UNLOCK1    (UNLOCK1)
  ) u_dp (
    .clk           (clk),
    .rst           (rst),
    .byteAddr      (byteAddr),
    .wrData        (wrData),
    .memData       (memData),
    .stb           (stb),
    .hit           (hit),
    .progReq       (progReq),
    .progAddr      (progAddr),
    .progData      (progData),
    .chipEraseReq  (chipEraseReq),
    .sectorEraseReq(sectorEraseReq),
    .eraseSector   (eraseSector)
  );

  assign mode = modeSig;

endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

  localparam int AW = 14;
  localparam int SL = 10;
  localparam logic [AW-1:0] UA0B = 14'h0AAA;  // word 0x555
  localparam logic [AW-1:0] UA1B = 14'h0554;  // word 0x2AA
  localparam logic [AW-1:0] QRYB = 14'h00AA;  // word 0x055

  logic        clk = 1'b0;
  logic        rst, wrEn, eraseDone;
  logic [AW-1:0] byteAddr;
  logic [15:0] wrData, memData;
  logic [1:0]  mode;
  logic        bypassOn, progReq, chipEraseReq, sectorEraseReq;
  logic [12:0] progAddr;
  logic [15:0] progData;
  logic [2:0]  eraseSector;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_seq #(.BUS_BYTES(2), .ADDR_W(AW), .SECTOR_LOG2(SL)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .byteAddr(byteAddr), .wrData(wrData),
    .memData(memData), .eraseDone(eraseDone), .mode(mode), .bypassOn(bypassOn),
    .progReq(progReq), .progAddr(progAddr), .progData(progData),
    .chipEraseReq(chipEraseReq), .sectorEraseReq(sectorEraseReq),
    .eraseSector(eraseSector)
  );

  function automatic logic [15:0] memAt(input logic [AW-1:0] ba);
    logic [15:0] w;
    w = 16'(ba >> 1);
    return 16'(w * 16'h9E37) ^ 16'h5A5A;
  endfunction

  assign memData = memAt(byteAddr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; byteAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic unlock();
    wr(UA0B, 16'h3CAA);
    wr(UA1B, 16'h3C55);
  endtask

  task automatic finishErase();
    @(negedge clk); eraseDone = 1'b1;
    @(negedge clk); eraseDone = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wrEn = 1'b0; eraseDone = 1'b0; byteAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 bypass", bypassOn, 0);
    chk("R1 requests", {progReq, chipEraseReq, sectorEraseReq}, 0);

    // R3 sweep of every command byte in the command cycle
    for (int v = 0; v < 256; v++) begin
      unlock();
      wr(UA0B, {8'h3C, 8'(v)});
      case (v)
        8'h90: begin
          chk("R3 ident", mode, 1);
          wr(UA0B, 16'h00F0);
          chk("R9 ident reset", mode, 0);
        end
        8'hA0: begin
          chk("R3 armed", mode, 3);
          wr(14'h0100, 16'hFFFF);
          chk("R4 progReq", progReq, 1);
          chk("R4 progData", progData, memAt(14'h0100));
          chk("R4 back to array", mode, 0);
        end
        8'h20: begin
          chk("R3 bypass on", bypassOn, 1);
          wr(14'h0000, 16'h00F0);
          chk("R9 bypass cleared", bypassOn, 0);
        end
        8'h80: begin
          unlock();
          wr(UA0B, 16'h0010);
          chk("R5 chip req", chipEraseReq, 1);
          chk("R5 chip mode", mode, 3);
          finishErase();
          chk("R6 after chip", mode, 0);
        end
        default: begin
          wr(UA0B, 16'h0090);
          chk("R3 other resets", mode, 0);
        end
      endcase
    end

    // R3 command cycle must hit UNLOCK0 outside bypass
    unlock();
    wr(UA1B, 16'h0090);
    chk("R3 cmd wrong addr", mode, 0);

    // R2 first-cycle address sweep, with aliasing of bits above 10
    for (int w = 16'h550; w < 16'h560; w++) begin
      wr(AW'(w << 1), 16'h00AA);
      wr(UA1B, 16'h0055);
      wr(UA0B, 16'h0090);
      chk("R2 first addr", mode, (w == 16'h555) ? 1 : 0);
      wr(UA0B, 16'h00F0);
    end
    wr(14'h1AAA, 16'h00AA);   // word 0xD55 aliases 0x555
    wr(14'h1554, 16'h0055);   // word 0xAAA aliases 0x2AA
    wr(UA0B, 16'h0090);
    chk("R2 alias", mode, 1);
    wr(UA0B, 16'h00F0);
    wr(14'h0AAB, 16'h00AA);   // lane bit ignored
    wr(UA1B, 16'h0055);
    wr(UA0B, 16'h0090);
    chk("R2 lane bit", mode, 1);
    wr(UA0B, 16'h00F0);
    // R2 second-cycle sweep
    for (int w = 16'h2A4; w < 16'h2B0; w++) begin
      wr(UA0B, 16'h00AA);
      wr(AW'(w << 1), 16'h0055);
      wr(UA0B, 16'h0090);
      chk("R2 second addr", mode, (w == 16'h2AA) ? 1 : 0);
      wr(UA0B, 16'h00F0);
    end
    wr(UA0B, 16'h00AB);
    wr(UA1B, 16'h0055);
    wr(UA0B, 16'h0090);
    chk("R2 wrong data", mode, 0);

    // R4 program sweep with R12 pulse width
    for (int i = 0; i < 32; i++) begin
      logic [12:0] wa;
      logic [15:0] d;
      wa = 13'((i * 37 + 5) & 16'h1FFF);
      d  = 16'(i * 16'h1357) ^ 16'hC3A5;
      unlock();
      wr(UA0B, 16'h00A0);
      wr({wa, 1'b0}, d);
      chk("R4 progReq", progReq, 1);
      chk("R4 progAddr", progAddr, wa);
      chk("R4 progData", progData, memAt({wa, 1'b0}) & d);
      @(negedge clk);
      chk("R12 pulse", progReq, 0);
    end

    // R5 R6 sector erase sweep
    for (int s = 0; s < 8; s++) begin
      logic [12:0] wa;
      wa = 13'((s << SL) | 16'h123);
      unlock();
      wr(UA0B, 16'h0080);
      unlock();
      wr({wa, 1'b0}, 16'h0030);
      chk("R5 sector req", sectorEraseReq, 1);
      chk("R12 single req", chipEraseReq, 0);
      chk("R5 sector index", eraseSector, s);
      chk("R5 status", mode, 3);
      wr(UA0B, 16'h00F0);
      chk("R6 F0 ignored", mode, 3);
      wr(UA0B, 16'h00AA);
      chk("R6 write ignored", mode, 3);
      chk("R6 no request", {progReq, chipEraseReq, sectorEraseReq}, 0);
      finishErase();
      chk("R6 done", mode, 0);
    end
    // R5 chip erase at the wrong address
    unlock();
    wr(UA0B, 16'h0080);
    unlock();
    wr(UA1B, 16'h0010);
    chk("R5 chip wrong addr", mode, 0);
    chk("R5 no chip req", chipEraseReq, 0);

    // R7 query from read array
    wr(QRYB, 16'h0098);
    chk("R7 query", mode, 2);
    wr(14'h0000, 16'h1234);
    chk("R7 write leaves", mode, 0);
    wr(QRYB, 16'h0098);
    wr(14'h0000, 16'h00F0);
    chk("R7 F0 leaves", mode, 0);
    wr(14'h00AC, 16'h0098);
    chk("R7 wrong word", mode, 0);

    // R8 query from identifier mode
    unlock();
    wr(UA0B, 16'h0090);
    wr(QRYB, 16'h0098);
    chk("R8 query", mode, 2);
    wr(14'h0000, 16'h00F0);
    chk("R8 back to ident", mode, 1);
    wr(QRYB, 16'h0098);
    wr(14'h0000, 16'h0012);
    chk("R8 other write", mode, 0);

    // R9 F0 is data in an armed program; F0 mid-unlock resets
    unlock();
    wr(UA0B, 16'h00A0);
    wr(14'h0200, 16'h00F0);
    chk("R9 F0 programmed", progReq, 1);
    chk("R9 F0 data", progData, memAt(14'h0200) & 16'h00F0);
    wr(UA0B, 16'h00AA);
    wr(14'h0000, 16'h00F0);
    wr(UA1B, 16'h0055);
    wr(UA0B, 16'h0090);
    chk("R9 mid-unlock reset", mode, 0);

    // R10 bypass programs
    unlock();
    wr(UA0B, 16'h0020);
    for (int k = 0; k < 8; k++) begin
      logic [AW-1:0] a;
      logic [15:0]   d;
      a = AW'((k * 16'h2F1 + 16'h40) << 1);
      d = 16'(~(k * 16'h0F0F));
      wr(14'h0000, 16'h00A0);
      wr(a, d);
      chk("R10 prog", progReq, 1);
      chk("R10 data", progData, memAt(a) & d);
      chk("R10 still bypass", bypassOn, 1);
    end
    // R10 erase in bypass returns to command cycle
    wr(14'h0000, 16'h0080);
    unlock();
    wr(14'h1000, 16'h0030);
    chk("R10 bypass sector", eraseSector, 2);
    finishErase();
    chk("R10 erase keeps bypass", bypassOn, 1);
    wr(14'h0000, 16'h00A0);
    wr(14'h0300, 16'h0F0F);
    chk("R10 prog after erase", progReq, 1);
    // R11 identifier under bypass, 0x00 exits
    wr(14'h0000, 16'h0090);
    chk("R11 ident", mode, 1);
    wr(14'h0000, 16'h0000);
    chk("R11 exit mode", mode, 0);
    chk("R11 exit bypass", bypassOn, 0);

    // R1 reset in the middle of bypass
    unlock();
    wr(UA0B, 16'h0020);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset clears bypass", bypassOn, 0);
    chk("R1 reset mode", mode, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule